// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits beside a processor's program counter and runs a counted loop without spending a branch instruction on each pass. A start command delivers three values together: the address of the first instruction in the body, the address of the last one, and the number of passes. From the next cycle on, the block watches the address the processor is about to retire. Each time that address equals the stored last address, the block takes one pass off the remaining count. If passes remain, it tells the processor to go back to the first instruction. If the count has just run out, it lets execution continue past the body and leaves the loop.

The processor drives the address it is currently handling on `nextPc`. In the same cycle it takes the redirect address from `pcOverride` whenever `overrideValid` is high. `loopActive` shows whether a loop is armed. Nested loops and interrupt handling are outside this block's scope.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset, `loopActive` and `overrideValid` are 0 and `pcOverride` is 0. The stored top, end and count are all reset to zero.
- R2: A start command (`startValid`=1) with a nonzero `startCount` makes `loopActive` 1 from the next cycle on.
- R3: A start command whose count is zero leaves `loopActive` 0 from the next cycle on. This also holds when a loop was already running.
- R4: `overrideValid` is 0 in every cycle where the loop is not active or `nextPc` differs from the stored end address.
- R5: When the loop is active, `nextPc` equals the stored end address and more than one pass remains, `overrideValid` is 1 in that same cycle. `pcOverride` then equals the stored top address, and the remaining count drops by one at the next edge.
- R6: When the loop is active, `nextPc` equals the end address and exactly one pass remains, `overrideValid` stays 0 (execution falls through) and `loopActive` is 0 from the next cycle on.
- R7: A loop started with count N and driven to its end address on every cycle produces exactly N-1 redirects before it ends.
- R8: A start command accepted while a loop runs replaces the top, end and count. Later matches use only the new values.
- R9: In a cycle that carries a start command, `overrideValid` is 0 and the count is not decremented.
- R10: The remaining count is never zero while `loopActive` is 1.
- R11: `pcOverride` always shows the stored top address, whether or not `overrideValid` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startValid | input | 1 | Start command strobe |
| startTop | input | ADDR_W | Address of the first instruction in the body |
| startEnd | input | ADDR_W | Address of the last instruction in the body |
| startCount | input | CNT_W | Number of passes |
| nextPc | input | ADDR_W | Address the processor is about to retire |
| pcOverride | output | ADDR_W | Redirect address (the stored top) |
| overrideValid | output | 1 | Processor must take `pcOverride` this cycle |
| loopActive | output | 1 | A loop is in progress |

## Verification
The bench builds the controller with an 8-bit address and a 4-bit count instead of the 16/16 defaults. This makes the largest count, 15, cheap to run to completion. That exposes the full count sequence, including the final pass from one to zero. The narrow address width also keeps the addresses in the vector table readable. The same vectors cover a start that arrives while the old end address is still matching, and a zero-count start that cancels a running loop.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new top/end/count
    logic step;   // end address reached: consume one pass
  } loop_strobe_t;
endpackage

// File: rtl/hwloop_datapath.sv
module hwloop_datapath
  import hwloop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  loop_strobe_t      strb,
  input  logic [ADDR_W-1:0] startTop,
  input  logic [ADDR_W-1:0] startEnd,
  input  logic [CNT_W-1:0]  startCount,
  input  logic [ADDR_W-1:0] nextPc,
  output logic [ADDR_W-1:0] loopTop,
  output logic              endMatch,
  output logic              lastIter,
  output logic              cntZero
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] loopEnd;
  logic [CNT_W-1:0]  iterCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loopTop <= '0;
      loopEnd <= '0;
      iterCnt <= '0;
    end else if (strb.load) begin
      loopTop <= startTop;
      loopEnd <= startEnd;
      iterCnt <= startCount;
    end else if (strb.step) begin
      iterCnt <= iterCnt - CNT_ONE;
    end
  end

  assign endMatch = (nextPc == loopEnd);
  assign lastIter = (iterCnt == CNT_ONE);
  assign cntZero  = (iterCnt == '0);

  // R5
  step_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> (iterCnt == $past(iterCnt) - CNT_ONE));

  // R8
  load_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (loopTop == $past(startTop) && iterCnt == $past(startCount)));
endmodule

// File: rtl/hwloop_control.sv
module hwloop_control
  import hwloop_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [CNT_W-1:0] startCount,
  input  logic             endMatch,
  input  logic             lastIter,
  output loop_strobe_t     strb,
  output logic             loopActive,
  output logic             redirect
);
  logic hit;
  logic startArms;

  assign startArms = (startCount != '0);
  assign hit       = loopActive && endMatch && !startValid;
  assign redirect  = hit && !lastIter;

  always_comb begin
    strb      = '0;
    strb.load = startValid;
    strb.step = hit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             loopActive <= 1'b0;
    else if (startValid)   loopActive <= startArms;
    else if (hit && lastIter) loopActive <= 1'b0;
  end

  // R2
  arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && startCount != '0) |=> loopActive);

  // R3
  zero_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && startCount == '0) |=> !loopActive);

  // R6
  fall_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loopActive && endMatch && lastIter && !startValid) |=> !loopActive);
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwloop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startTop,
  input  logic [ADDR_W-1:0] startEnd,
  input  logic [CNT_W-1:0]  startCount,
  input  logic [ADDR_W-1:0] nextPc,
  output logic [ADDR_W-1:0] pcOverride,
  output logic              overrideValid,
  output logic              loopActive
);
  loop_strobe_t strb;
  logic endMatch, lastIter, cntZero, redirect;

  hwloop_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .startTop(startTop), .startEnd(startEnd), .startCount(startCount),
    .nextPc(nextPc), .loopTop(pcOverride),
    .endMatch(endMatch), .lastIter(lastIter), .cntZero(cntZero)
  );

  hwloop_control #(.CNT_W(CNT_W)) ctl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startCount(startCount),
    .endMatch(endMatch), .lastIter(lastIter),
    .strb(strb), .loopActive(loopActive), .redirect(redirect)
  );

  assign overrideValid = redirect;

  // R10
  live_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    loopActive |-> !cntZero);

  // R9
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    startValid |-> !overrideValid);

  // R4
  valid_needs_loop_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrideValid |-> loopActive);
endmodule

// File: tb/hwloop_ctrl_test.sv
module hwloop_ctrl_test;
  localparam int AW = 8;
  localparam int CW = 4;

  typedef struct packed {
    logic          st;
    logic [AW-1:0] top;
    logic [AW-1:0] fin;
    logic [CW-1:0] cnt;
    logic [AW-1:0] pc;
    logic          expAct;
    logic          expVal;
    logic [AW-1:0] expOvr;
  } vec_t;

  localparam int NV = 20;
  // start, top, end, count, pc, active, valid, override
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'h00, 4'd0, 8'h00, 1'b0, 1'b0, 8'h00}, // 0  R4 idle
    {1'b1, 8'h10, 8'h13, 4'd3, 8'h05, 1'b0, 1'b0, 8'h00}, // 1  start
    {1'b0, 8'h00, 8'h00, 4'd0, 8'h11, 1'b1, 1'b0, 8'h10}, // 2  R2 R4 R11
    {1'b0, 8'h00, 8'h00, 4'd0, 8'h13, 1'b1, 1'b1, 8'h10}, // 3  R5
    {1'b0, 8'h00, 8'h00, 4'd0, 8'h10, 1'b1, 1'b0, 8'h10}, // 4  R4
    {1'b0, 8'h00, 8'h00, 4'd0, 8'h13, 1'b1, 1'b1, 8'h10}, // 5  R5
    {1'b0, 8'h00, 8'h00, 4'd0, 8'h13, 1'b1, 1'b0, 8'h10}, // 6  R6 last pass
    {1'b0, 8'h00, 8'h00, 4'd0, 8'h13, 1'b0, 1'b0, 8'h10}, // 7  R6 R7 ended
    {1'b1, 8'h20, 8'h22, 4'd0, 8'h22, 1'b0, 1'b0, 8'h10}, // 8  zero start
    {1'b0, 8'h00, 8'h00, 4'd0, 8'h22, 1'b0, 1'b0, 8'h20}, // 9  R3
    {1'b1, 8'h30, 8'h31, 4'd5, 8'h00, 1'b0, 1'b0, 8'h20}, // 10
    {1'b0, 8'h00, 8'h00, 4'd0, 8'h31, 1'b1, 1'b1, 8'h30}, // 11 R5
    {1'b1, 8'h40, 8'h44, 4'd2, 8'h31, 1'b1, 1'b0, 8'h30}, // 12 R9
    {1'b0, 8'h00, 8'h00, 4'd0, 8'h31, 1'b1, 1'b0, 8'h40}, // 13 R8 old end
    {1'b0, 8'h00, 8'h00, 4'd0, 8'h44, 1'b1, 1'b1, 8'h40}, // 14 R8 new end
    {1'b0, 8'h00, 8'h00, 4'd0, 8'h44, 1'b1, 1'b0, 8'h40}, // 15 R6
    {1'b0, 8'h00, 8'h00, 4'd0, 8'h44, 1'b0, 1'b0, 8'h40}, // 16 R6
    {1'b1, 8'h50, 8'h51, 4'd2, 8'h00, 1'b0, 1'b0, 8'h40}, // 17
    {1'b1, 8'h60, 8'h61, 4'd0, 8'h00, 1'b1, 1'b0, 8'h50}, // 18 cancel
    {1'b0, 8'h00, 8'h00, 4'd0, 8'h51, 1'b0, 1'b0, 8'h60}  // 19 R3 R8
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0;
  logic [AW-1:0] startTop = '0, startEnd = '0, nextPc = '0;
  logic [CW-1:0] startCount = '0;
  logic [AW-1:0] pcOverride;
  logic overrideValid, loopActive;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hwloop_ctrl #(.ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startTop(startTop),
    .startEnd(startEnd), .startCount(startCount), .nextPc(nextPc),
    .pcOverride(pcOverride), .overrideValid(overrideValid), .loopActive(loopActive)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at falling edge, sample 1 ns later (1 ns before rising edge)
  task automatic drive(input logic st, input logic [AW-1:0] t, input logic [AW-1:0] e,
                       input logic [CW-1:0] c, input logic [AW-1:0] pc);
    @(negedge clk);
    startValid = st; startTop = t; startEnd = e; startCount = c; nextPc = pc;
    #1;
  endtask

  // R7: N passes yield N-1 redirects
  task automatic run_loop(input logic [CW-1:0] n, input logic [AW-1:0] t, input logic [AW-1:0] e);
    int redirects = 0;
    int guard = 0;
    drive(1'b1, t, e, n, 8'h00);
    drive(1'b0, '0, '0, '0, e);
    while (loopActive && guard < 64) begin
      if (overrideValid) redirects++;
      guard++;
      drive(1'b0, '0, '0, '0, e);
    end
    check("R7 redirect count", redirects, 32'(n) - 1);
    check("R6 loop ended", loopActive, 0);
  endtask

  initial begin
    #1;
    // R1 reset state
    check("R1 active", loopActive, 0);
    check("R1 valid", overrideValid, 0);
    check("R1 override", pcOverride, 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(VEC[i]);
      drive(v.st, v.top, v.fin, v.cnt, v.pc);
      check($sformatf("R2-R11 vec%0d active", i), loopActive, v.expAct);
      check($sformatf("R4 R5 R9 vec%0d valid", i), overrideValid, v.expVal);
      check($sformatf("R11 vec%0d override", i), pcOverride, v.expOvr);
    end

    run_loop(4'd15, 8'h70, 8'h7f);
    run_loop(4'd1, 8'h80, 8'h80);
    run_loop(4'd2, 8'h90, 8'h95);

    // R1 reset in mid-loop clears everything
    drive(1'b1, 8'hA0, 8'hA2, 4'd9, 8'h00);
    drive(1'b0, '0, '0, '0, 8'hA2);
    check("R5 mid-loop valid", overrideValid, 1);
    rstN = 1'b0;
    #0.5;
    check("R1 reset active", loopActive, 0);
    check("R1 reset override", pcOverride, 0);
    @(negedge clk);
    rstN = 1'b1;
    drive(1'b0, '0, '0, '0, 8'h00);
    check("R1 R4 after reset", overrideValid, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule